// File: doc/BRIEF.md
# Confidence-Gated Load Value Predictor

This block guesses the data a load will return before memory answers. A history table, indexed by the low bits of the load's program counter, holds five learned values, a last value with a stride, and a short history of which candidate was right on recent loads. That history, folded with the program counter, selects a set of confidence counters, one per candidate. A lookup offers eight candidates: the five learned values, the constants zero and one, and last value plus stride. It returns the strongest candidate whose counter has reached the threshold, or says that it has no prediction. In multi-value mode it also flags every candidate that has reached the threshold.

Training is split in time. When the pipeline consumes a predicted value, the use port advances the stride state at once, so that back-to-back instances of a striding load can chain. The learned values, the confidence counters and the candidate history move only when the load commits with its real data. Thread spawning, recovery and the rest of the pipeline live outside the block.

Top module: `lvp_predictor`

## Requirements
- R1: Only loads take part: a lookup with `lk_load` low gives `pr_valid` 0 and `pr_mask` 0, and a training request with `tr_load` low changes no state.
- R2: The history entry is chosen by `pc[5:0]` with no tag, so aliasing PCs share one entry. Candidate codes on `pr_cand`: 0 to 4 learned slots, 5 constant zero, 6 constant one, 7 last value plus stride.
- R3: The confidence set is `pc[7:0]` XOR the folded candidate history, where history bit i is XORed into set bit (i mod 8). The 9-bit history holds the last three correct candidate codes, newest in bits [2:0]. Each training step shifts it left by 3.
- R4: On training, every one of the eight counters in the selected set changes. It rises by 1, up to 32, if its candidate equals the committed value. Otherwise it falls by 8, down to 0.
- R5: A candidate is eligible only when its counter is at least 12. `pr_valid` is 1 in the cycle after a load lookup exactly when some candidate is eligible, and 0 after a cycle with no lookup.
- R6: A use request sets the entry's last value to `use_value` and its stride to `use_value` minus the old last value, modulo 2^32. It leaves the learned values unchanged.
- R7: The best candidate has the highest counter, and a tie goes to the lowest code, so the stride candidate loses every tie. With `multi_mode` low, `pr_mask` is the one-hot mask of the best candidate, or 0. With `multi_mode` high, it has bit c set for every eligible candidate c.
- R8: When training finds the committed value in no learned slot, the value goes into the learned slot with the lowest counter (ties to the lower slot), and that counter becomes 0. The code shifted into the history is the lowest matching candidate code. If no candidate matches, it is the replaced slot.
- R9: After reset all values, strides, histories and counters are zero, and no prediction is made until training has raised a counter.
- R10: `pr_cand_vals` carries all eight candidate values of the looked-up entry, with candidate c in bits [32c+31:32c]. `pr_value` is the value of `pr_cand`. Results appear one clock after the lookup is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| multi_mode | input | 1 | Report all eligible candidates in `pr_mask` |
| lk_valid | input | 1 | Lookup request |
| lk_load | input | 1 | Lookup instruction is a load |
| lk_pc | input | 32 | Lookup program counter |
| use_valid | input | 1 | Predicted value consumed |
| use_pc | input | 32 | Program counter of the consumed prediction |
| use_value | input | 32 | Value consumed |
| tr_valid | input | 1 | Commit-time training request |
| tr_load | input | 1 | Trained instruction is a load |
| tr_pc | input | 32 | Program counter being trained |
| tr_value | input | 32 | Committed load data |
| pr_valid | output | 1 | A prediction is offered |
| pr_value | output | 32 | Predicted value |
| pr_cand | output | 3 | Code of the chosen candidate |
| pr_mask | output | 8 | Best-candidate mask or eligible-candidate mask |
| pr_cand_vals | output | 256 | All eight candidate values |

## Verification
Repeated commits of zero train several candidates at once, which separates the tie-break from the threshold boundary at 12. A single differing commit then shows the drop by 8 and the replacement of the weakest learned slot. A striding sequence fed through the use port shows the speculative stride path, and it also walks the history through its shift so that the confidence set moves before it settles. Random traffic mixes a few PCs, including two that alias in the history table but not in the confidence table, biased values, non-load requests and both mask modes. An independent model of the tables predicts every output of each lookup.

// File: rtl/lvp_pkg.sv
package lvp_pkg;
  localparam int N_LEARN     = 5;
  localparam int N_CAND      = 8;
  localparam int CIDX_W      = 3;
  localparam int CAND_ZERO   = 5;
  localparam int CAND_ONE    = 6;
  localparam int CAND_STRIDE = 7;
  localparam int PAT_DEPTH   = 3;
  localparam int PAT_W       = PAT_DEPTH * CIDX_W;
  localparam int CONF_W      = 6;

  typedef logic [CIDX_W-1:0] cidx_t;
  typedef logic [CONF_W-1:0] conf_t;
endpackage

// File: rtl/lvp_hist_table.sv
module lvp_hist_table import lvp_pkg::*; #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [AW-1:0]                  a_idx,
  output logic [N_LEARN-1:0][DATA_W-1:0] a_learn,
  output logic [DATA_W-1:0]              a_last,
  output logic [DATA_W-1:0]              a_stride,
  output logic [PAT_W-1:0]               a_pat,
  input  logic [AW-1:0]                  b_idx,
  output logic [N_LEARN-1:0][DATA_W-1:0] b_learn,
  output logic [DATA_W-1:0]              b_last,
  output logic [DATA_W-1:0]              b_stride,
  output logic [PAT_W-1:0]               b_pat,
  input  logic                           use_we,
  input  logic [AW-1:0]                  use_idx,
  input  logic [DATA_W-1:0]              use_value,
  input  logic                           tr_we,
  input  logic [AW-1:0]                  tr_idx,
  input  logic                           slot_we,
  input  cidx_t                          slot,
  input  logic [DATA_W-1:0]              tr_value,
  input  logic [PAT_W-1:0]               tr_pat
);
  logic [N_LEARN-1:0][DATA_W-1:0] learn_q  [DEPTH];
  logic [DATA_W-1:0]              last_q   [DEPTH];
  logic [DATA_W-1:0]              stride_q [DEPTH];
  logic [PAT_W-1:0]               pat_q    [DEPTH];

  logic [DATA_W-1:0] stride_nxt;

  always_comb begin
    a_learn  = learn_q[a_idx];
    a_last   = last_q[a_idx];
    a_stride = stride_q[a_idx];
    a_pat    = pat_q[a_idx];
    b_learn  = learn_q[b_idx];
    b_last   = last_q[b_idx];
    b_stride = stride_q[b_idx];
    b_pat    = pat_q[b_idx];
  end

  // speculative stride step: distance from the previous consumed value
  always_comb stride_nxt = use_value - last_q[use_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        learn_q[e]  <= '0;
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        pat_q[e]    <= '0;
      end
    end else begin
      if (use_we) begin
        last_q[use_idx]   <= use_value;
        stride_q[use_idx] <= stride_nxt;
      end
      if (tr_we) begin
        pat_q[tr_idx] <= tr_pat;
        if (slot_we) learn_q[tr_idx][slot] <= tr_value;
      end
    end
  end

  // R6: the consumed value becomes the entry's last value
  p_use_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    use_we |=> last_q[$past(use_idx)] == $past(use_value));

  // R6: the use path never disturbs learned values
  p_use_keeps_learn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_we && !tr_we) |=> learn_q[$past(use_idx)] == $past(learn_q[use_idx]));
endmodule

// File: rtl/lvp_conf_table.sv
module lvp_conf_table import lvp_pkg::*; #(
  parameter  int SETS     = 256,
  parameter  int CONF_MAX = 32,
  localparam int CAW      = $clog2(SETS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CAW-1:0]           a_idx,
  output logic [N_CAND-1:0][CONF_W-1:0] a_conf,
  input  logic [CAW-1:0]           b_idx,
  output logic [N_CAND-1:0][CONF_W-1:0] b_conf,
  input  logic                     we,
  input  logic [CAW-1:0]           widx,
  input  logic [N_CAND-1:0][CONF_W-1:0] wdata
);
  localparam conf_t MAX_C = conf_t'(CONF_MAX);

  logic [N_CAND-1:0][CONF_W-1:0] conf_q [SETS];

  always_comb begin
    a_conf = conf_q[a_idx];
    b_conf = conf_q[b_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) conf_q[s] <= '0;
    end else if (we) begin
      conf_q[widx] <= wdata;
    end
  end

  for (genvar c = 0; c < N_CAND; c++) begin : g_cap
    // R4: no counter is ever written above its ceiling
    p_conf_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> wdata[c] <= MAX_C);
  end
endmodule

// File: rtl/lvp_select.sv
module lvp_select import lvp_pkg::*; #(
  parameter int CONF_THR = 12
) (
  input  logic [N_CAND-1:0][CONF_W-1:0] conf,
  output logic [N_CAND-1:0]             above,
  output logic                          best_ok,
  output cidx_t                         best_idx
);
  localparam conf_t THR_C = conf_t'(CONF_THR);

  conf_t best_conf;

  always_comb begin
    best_ok   = 1'b0;
    best_idx  = '0;
    best_conf = '0;
    for (int c = 0; c < N_CAND; c++) begin
      above[c] = conf[c] >= THR_C;
      // strict compare keeps the lowest code on ties
      if (above[c] && (!best_ok || conf[c] > best_conf)) begin
        best_ok   = 1'b1;
        best_idx  = cidx_t'(c);
        best_conf = conf[c];
      end
    end
  end
endmodule

// File: rtl/lvp_trainer.sv
module lvp_trainer import lvp_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int CONF_MAX = 32,
  parameter int CONF_INC = 1,
  parameter int CONF_DEC = 8
) (
  input  logic [N_CAND-1:0][DATA_W-1:0] cand,
  input  logic [N_CAND-1:0][CONF_W-1:0] conf_old,
  input  logic [DATA_W-1:0]             actual,
  input  logic [PAT_W-1:0]              pat_old,
  output logic [N_CAND-1:0][CONF_W-1:0] conf_new,
  output logic                          slot_we,
  output cidx_t                         slot,
  output logic [PAT_W-1:0]              pat_new
);
  localparam logic [CONF_W:0] MAX_W = (CONF_W+1)'(CONF_MAX);
  localparam logic [CONF_W:0] INC_W = (CONF_W+1)'(CONF_INC);
  localparam conf_t           DEC_C = conf_t'(CONF_DEC);

  logic [N_CAND-1:0] match;
  logic              learn_hit;
  cidx_t             victim;
  conf_t             vconf;
  cidx_t             correct;
  logic [CONF_W:0]   up;

  always_comb begin
    for (int c = 0; c < N_CAND; c++) match[c] = cand[c] == actual;
    learn_hit = |match[N_LEARN-1:0];
  end

  // weakest learned slot, lowest slot on ties
  always_comb begin
    victim = '0;
    vconf  = conf_old[0];
    for (int c = 1; c < N_LEARN; c++) begin
      if (conf_old[c] < vconf) begin
        victim = cidx_t'(c);
        vconf  = conf_old[c];
      end
    end
  end

  always_comb begin
    correct = victim;
    for (int c = N_CAND-1; c >= 0; c--) begin
      if (match[c]) correct = cidx_t'(c);
    end
    pat_new = {pat_old[PAT_W-CIDX_W-1:0], correct};
    slot_we = !learn_hit;
    slot    = victim;
  end

  always_comb begin
    for (int c = 0; c < N_CAND; c++) begin
      up = {1'b0, conf_old[c]} + INC_W;
      if (!learn_hit && c == int'(victim)) begin
        conf_new[c] = '0;
      end else if (match[c]) begin
        conf_new[c] = (up > MAX_W) ? MAX_W[CONF_W-1:0] : up[CONF_W-1:0];
      end else begin
        conf_new[c] = (conf_old[c] >= DEC_C) ? conf_old[c] - DEC_C : '0;
      end
    end
  end
endmodule

// File: rtl/lvp_predictor.sv
module lvp_predictor import lvp_pkg::*; #(
  parameter  int PC_W       = 32,
  parameter  int DATA_W     = 32,
  parameter  int HIST_DEPTH = 64,
  parameter  int CONF_SETS  = 256,
  parameter  int CONF_MAX   = 32,
  parameter  int CONF_THR   = 12,
  parameter  int CONF_INC   = 1,
  parameter  int CONF_DEC   = 8,
  localparam int AW         = $clog2(HIST_DEPTH),
  localparam int CAW        = $clog2(CONF_SETS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     multi_mode,
  input  logic                     lk_valid,
  input  logic                     lk_load,
  input  logic [PC_W-1:0]          lk_pc,
  input  logic                     use_valid,
  input  logic [PC_W-1:0]          use_pc,
  input  logic [DATA_W-1:0]        use_value,
  input  logic                     tr_valid,
  input  logic                     tr_load,
  input  logic [PC_W-1:0]          tr_pc,
  input  logic [DATA_W-1:0]        tr_value,
  output logic                     pr_valid,
  output logic [DATA_W-1:0]        pr_value,
  output logic [CIDX_W-1:0]        pr_cand,
  output logic [N_CAND-1:0]        pr_mask,
  output logic [N_CAND*DATA_W-1:0] pr_cand_vals
);
  localparam conf_t THR_C = conf_t'(CONF_THR);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  function automatic logic [CAW-1:0] set_of(input logic [PC_W-1:0] pc,
                                            input logic [PAT_W-1:0] pat);
    logic [CAW-1:0] f;
    f = pc[CAW-1:0];
    for (int i = 0; i < PAT_W; i++) f[i % CAW] = f[i % CAW] ^ pat[i];
    return f;
  endfunction

  // history table
  logic [N_LEARN-1:0][DATA_W-1:0] a_learn, b_learn;
  logic [DATA_W-1:0]              a_last, a_stride, b_last, b_stride;
  logic [PAT_W-1:0]               a_pat, b_pat, pat_new;
  logic                           tr_do, slot_we;
  cidx_t                          slot;

  assign tr_do = tr_valid && tr_load;

  lvp_hist_table #(.DATA_W(DATA_W), .DEPTH(HIST_DEPTH)) u_hist (
    .clk       (clk),
    .rst_n     (rst_q),
    .a_idx     (lk_pc[AW-1:0]),
    .a_learn   (a_learn),
    .a_last    (a_last),
    .a_stride  (a_stride),
    .a_pat     (a_pat),
    .b_idx     (tr_pc[AW-1:0]),
    .b_learn   (b_learn),
    .b_last    (b_last),
    .b_stride  (b_stride),
    .b_pat     (b_pat),
    .use_we    (use_valid),
    .use_idx   (use_pc[AW-1:0]),
    .use_value (use_value),
    .tr_we     (tr_do),
    .tr_idx    (tr_pc[AW-1:0]),
    .slot_we   (slot_we && tr_do),
    .slot      (slot),
    .tr_value  (tr_value),
    .tr_pat    (pat_new)
  );

  // candidate assembly for both read ports
  logic [N_CAND-1:0][DATA_W-1:0] cand_a, cand_b;
  always_comb begin
    for (int c = 0; c < N_LEARN; c++) begin
      cand_a[c] = a_learn[c];
      cand_b[c] = b_learn[c];
    end
    cand_a[CAND_ZERO]   = '0;
    cand_b[CAND_ZERO]   = '0;
    cand_a[CAND_ONE]    = DATA_W'(1);
    cand_b[CAND_ONE]    = DATA_W'(1);
    cand_a[CAND_STRIDE] = a_last + a_stride;
    cand_b[CAND_STRIDE] = b_last + b_stride;
  end

  // confidence table
  logic [CAW-1:0]                set_a, set_b;
  logic [N_CAND-1:0][CONF_W-1:0] conf_a, conf_b, conf_new;

  assign set_a = set_of(lk_pc, a_pat);
  assign set_b = set_of(tr_pc, b_pat);

  lvp_conf_table #(.SETS(CONF_SETS), .CONF_MAX(CONF_MAX)) u_conf (
    .clk    (clk),
    .rst_n  (rst_q),
    .a_idx  (set_a),
    .a_conf (conf_a),
    .b_idx  (set_b),
    .b_conf (conf_b),
    .we     (tr_do),
    .widx   (set_b),
    .wdata  (conf_new)
  );

  lvp_trainer #(
    .DATA_W(DATA_W), .CONF_MAX(CONF_MAX), .CONF_INC(CONF_INC), .CONF_DEC(CONF_DEC)
  ) u_train (
    .cand     (cand_b),
    .conf_old (conf_b),
    .actual   (tr_value),
    .pat_old  (b_pat),
    .conf_new (conf_new),
    .slot_we  (slot_we),
    .slot     (slot),
    .pat_new  (pat_new)
  );

  logic [N_CAND-1:0] above;
  logic              best_ok;
  cidx_t             best_idx;

  lvp_select #(.CONF_THR(CONF_THR)) u_sel (
    .conf     (conf_a),
    .above    (above),
    .best_ok  (best_ok),
    .best_idx (best_idx)
  );

  // output stage: next state
  logic                          lk_hit;
  logic                          valid_d;
  logic [N_CAND-1:0]             mask_d;
  logic                          valid_q;
  logic [N_CAND-1:0]             mask_q;
  logic [DATA_W-1:0]             value_q;
  cidx_t                         cand_q;
  logic [N_CAND-1:0][DATA_W-1:0] vals_q;

  always_comb begin
    lk_hit  = lk_valid && lk_load;
    valid_d = lk_hit && best_ok;
    if (!lk_hit)         mask_d = '0;
    else if (multi_mode) mask_d = above;
    else if (best_ok)    mask_d = N_CAND'(1) << best_idx;
    else                 mask_d = '0;
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      value_q <= '0;
      cand_q  <= '0;
      vals_q  <= '0;
    end else begin
      valid_q <= valid_d;
      mask_q  <= mask_d;
      if (lk_valid) begin
        value_q <= cand_a[best_idx];
        cand_q  <= best_idx;
        vals_q  <= cand_a;
      end
    end
  end

  assign pr_valid     = valid_q;
  assign pr_mask      = mask_q;
  assign pr_value     = value_q;
  assign pr_cand      = cand_q;
  assign pr_cand_vals = vals_q;

  logic lvp_unused;
  assign lvp_unused = ^{lk_pc[PC_W-1:CAW], use_pc[PC_W-1:AW], tr_pc[PC_W-1:CAW]};

  // R5: a chosen candidate has reached the threshold
  p_best_thr_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (lk_hit && best_ok) |-> conf_a[best_idx] >= THR_C);

  // R5: no lookup, no prediction in the following cycle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !lk_valid |=> !pr_valid);

  for (genvar c = 0; c < N_CAND; c++) begin : g_best
    // R7: no eligible candidate is stronger than the chosen one
    p_best_max_r7: assert property (@(posedge clk) disable iff (!rst_q)
      (best_ok && above[c]) |-> conf_a[c] <= conf_a[best_idx]);
  end

  // R1: non-load lookups report nothing
  p_nonload_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (lk_valid && !lk_load) |=> (!pr_valid && pr_mask == '0));

  // R7: single mode flags at most one candidate
  p_single_mask_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (lk_valid && !multi_mode) |=> $onehot0(pr_mask));

  // R7: the reported candidate is always flagged in the mask
  p_mask_has_best_r7: assert property (@(posedge clk) disable iff (!rst_q)
    pr_valid |-> pr_mask[pr_cand]);
endmodule

// File: tb/lvp_predictor_bench.sv
`timescale 1ns/1ps
module lvp_predictor_bench;
  logic         clk, rst_n, multi_mode;
  logic         lk_valid, lk_load, use_valid, tr_valid, tr_load;
  logic [31:0]  lk_pc, use_pc, use_value, tr_pc, tr_value;
  logic         pr_valid;
  logic [31:0]  pr_value;
  logic [2:0]   pr_cand;
  logic [7:0]   pr_mask;
  logic [255:0] pr_cand_vals;

  lvp_predictor u_lvp_predictor (
    .clk(clk), .rst_n(rst_n), .multi_mode(multi_mode),
    .lk_valid(lk_valid), .lk_load(lk_load), .lk_pc(lk_pc),
    .use_valid(use_valid), .use_pc(use_pc), .use_value(use_value),
    .tr_valid(tr_valid), .tr_load(tr_load), .tr_pc(tr_pc), .tr_value(tr_value),
    .pr_valid(pr_valid), .pr_value(pr_value), .pr_cand(pr_cand),
    .pr_mask(pr_mask), .pr_cand_vals(pr_cand_vals)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model of the tables
  logic [31:0] m_learn  [64][5];
  logic [31:0] m_last   [64];
  logic [31:0] m_stride [64];
  logic [8:0]  m_pat    [64];
  int          m_conf   [256][8];

  bit           pend, e_load, e_valid;
  logic [31:0]  e_value;
  logic [2:0]   e_cand;
  logic [7:0]   e_mask;
  logic [255:0] e_vals;
  string        e_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_set(input logic [31:0] pc);
    logic [8:0] p;
    logic [7:0] f;
    p = m_pat[pc[5:0]];
    f = pc[7:0];
    for (int i = 0; i < 9; i++) f[i % 8] = f[i % 8] ^ p[i];
    return f;
  endfunction

  function automatic logic [31:0] m_cand(input int e, input int c);
    if (c < 5)  return m_learn[e][c];
    if (c == 5) return 32'd0;
    if (c == 6) return 32'd1;
    return m_last[e] + m_stride[e];
  endfunction

  task automatic model_train(input logic [31:0] pc, input logic [31:0] v);
    int e, s, vic, corr;
    bit hit;
    bit mt [8];
    e = int'(pc[5:0]);
    s = int'(m_set(pc));
    hit = 1'b0;
    for (int c = 0; c < 8; c++) begin
      mt[c] = (m_cand(e, c) == v);
      if (c < 5 && mt[c]) hit = 1'b1;
    end
    vic = 0;
    for (int c = 1; c < 5; c++) if (m_conf[s][c] < m_conf[s][vic]) vic = c;
    corr = vic;
    for (int c = 7; c >= 0; c--) if (mt[c]) corr = c;
    for (int c = 0; c < 8; c++) begin
      if (mt[c]) m_conf[s][c] = (m_conf[s][c] + 1 > 32) ? 32 : m_conf[s][c] + 1;
      else       m_conf[s][c] = (m_conf[s][c] < 8) ? 0 : m_conf[s][c] - 8;
    end
    if (!hit) begin
      m_learn[e][vic] = v;
      m_conf[s][vic]  = 0;
    end
    m_pat[e] = {m_pat[e][5:0], 3'(corr)};
  endtask

  task automatic model_use(input logic [31:0] pc, input logic [31:0] v);
    int e;
    e = int'(pc[5:0]);
    m_stride[e] = v - m_last[e];
    m_last[e]   = v;
  endtask

  task automatic model_lookup(input logic [31:0] pc, input bit mm);
    int e, s, bc;
    e = int'(pc[5:0]);
    s = int'(m_set(pc));
    e_valid = 1'b0;
    bc = 0;
    e_mask = '0;
    for (int c = 0; c < 8; c++) begin
      e_vals[c*32 +: 32] = m_cand(e, c);
      if (m_conf[s][c] >= 12) begin
        if (mm) e_mask[c] = 1'b1;
        if (!e_valid || m_conf[s][c] > m_conf[s][bc]) begin
          e_valid = 1'b1;
          bc = c;
        end
      end
    end
    e_cand  = 3'(bc);
    e_value = m_cand(e, bc);
    if (!mm && e_valid) e_mask[bc] = 1'b1;
  endtask

  task automatic check_pending();
    if (!pend) return;
    if (!e_load) begin
      chk(pr_valid == 1'b0 && pr_mask == 8'h0, "R1", "non-load lookup",
          {pr_valid, pr_mask}, 256'h0);
    end else begin
      chk(pr_valid == e_valid, e_tag, "pr_valid", pr_valid, e_valid);
      chk(pr_mask == e_mask, "R7", "pr_mask", pr_mask, e_mask);
      if (e_valid)
        chk(pr_cand == e_cand && pr_value == e_value, "R7", "cand/value",
            {pr_cand, pr_value}, {e_cand, e_value});
      chk(pr_cand_vals == e_vals, "R10", "candidate values", pr_cand_vals, e_vals);
    end
  endtask

  task automatic step(input bit lkv, input bit lkl, input logic [31:0] lpc, input bit mm,
                      input bit usv, input logic [31:0] upc, input logic [31:0] uval,
                      input bit trv, input bit trl, input logic [31:0] tpc,
                      input logic [31:0] tval, input string tag);
    @(negedge clk);
    check_pending();
    lk_valid = lkv; lk_load = lkl; lk_pc = lpc; multi_mode = mm;
    use_valid = usv; use_pc = upc; use_value = uval;
    tr_valid = trv; tr_load = trl; tr_pc = tpc; tr_value = tval;
    pend = lkv;
    e_load = lkl;
    e_tag = tag;
    if (lkv) model_lookup(lpc, mm);
    if (trv && trl) model_train(tpc, tval);
    if (usv) model_use(upc, uval);
  endtask

  task automatic lookup(input logic [31:0] pc, input bit mm, input bit ld, input string tag);
    step(1'b1, ld, pc, mm, 1'b0, 0, 0, 1'b0, 1'b0, 0, 0, tag);
  endtask
  task automatic train(input logic [31:0] pc, input logic [31:0] v, input bit ld);
    step(1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b1, ld, pc, v, "");
  endtask
  task automatic use_op(input logic [31:0] pc, input logic [31:0] v);
    step(1'b0, 1'b0, 0, 1'b0, 1'b1, pc, v, 1'b0, 1'b0, 0, 0, "");
  endtask

  logic [31:0] pcs [5];
  logic [31:0] fav [5];

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] nxt;
    void'($urandom(32'h5eed_1234));
    pcs[0] = 32'h10; pcs[1] = 32'h24; pcs[2] = 32'h33; pcs[3] = 32'h50; pcs[4] = 32'h90;
    fav[0] = 32'h0;  fav[1] = 32'h2a; fav[2] = 32'h1;  fav[3] = 32'hdead; fav[4] = 32'h7;
    for (int e = 0; e < 64; e++) begin
      for (int c = 0; c < 5; c++) m_learn[e][c] = '0;
      m_last[e] = '0; m_stride[e] = '0; m_pat[e] = '0;
    end
    for (int s = 0; s < 256; s++) for (int c = 0; c < 8; c++) m_conf[s][c] = 0;
    pend = 1'b0;
    rst_n = 1'b0; multi_mode = 1'b0;
    lk_valid = 1'b0; lk_load = 1'b0; lk_pc = '0;
    use_valid = 1'b0; use_pc = '0; use_value = '0;
    tr_valid = 1'b0; tr_load = 1'b0; tr_pc = '0; tr_value = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(pr_valid == 1'b0, "R9", "pr_valid after reset", pr_valid, 0);
    chk(pr_mask == 8'h0, "R9", "pr_mask after reset", pr_mask, 0);
    lookup(32'h40, 1'b1, 1'b1, "R9");

    // R5/R4: commits of zero climb several counters; threshold at 12
    for (int i = 0; i < 14; i++) begin
      train(32'h10, 32'h0, 1'b1);
      lookup(32'h10, 1'b0, 1'b1, "R5");
    end
    lookup(32'h10, 1'b1, 1'b1, "R7");
    // R1: non-load lookup and non-load training
    lookup(32'h10, 1'b0, 1'b0, "R1");
    train(32'h10, 32'h5, 1'b0);
    lookup(32'h10, 1'b0, 1'b1, "R1");
    // R2: aliasing PC shares the entry but not the confidence set
    lookup(32'h50, 1'b1, 1'b1, "R2");
    // R4/R8: a miss drops counters and replaces the weakest slot
    train(32'h10, 32'h5, 1'b1);
    lookup(32'h10, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 13; i++) begin
      train(32'h10, 32'h5, 1'b1);
      lookup(32'h10, 1'b0, 1'b1, "R4");
    end

    // R6/R3: striding load chained through the use port
    use_op(32'h24, 32'd100);
    use_op(32'h24, 32'd104);
    lookup(32'h24, 1'b0, 1'b1, "R6");
    nxt = 32'd108;
    for (int i = 0; i < 18; i++) begin
      train(32'h24, nxt, 1'b1);
      lookup(32'h24, 1'b1, 1'b1, "R3");
      use_op(32'h24, nxt);
      lookup(32'h24, 1'b0, 1'b1, "R6");
      nxt = nxt + 32'd4;
    end

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int kl, kt, ku, r;
      logic [31:0] tv;
      kl = $urandom_range(0, 4);
      kt = $urandom_range(0, 4);
      ku = $urandom_range(0, 4);
      r  = $urandom_range(0, 9);
      if (r < 7)      tv = fav[kt];
      else if (r < 9) tv = 32'($urandom_range(0, 3));
      else            tv = m_cand(int'(pcs[kt][5:0]), 7);
      step(($urandom_range(0, 1) == 1), ($urandom_range(0, 7) != 0), pcs[kl],
           ($urandom_range(0, 1) == 1),
           ($urandom_range(0, 3) == 0), pcs[ku],
           m_cand(int'(pcs[ku][5:0]), 7) + 32'($urandom_range(0, 1)),
           ($urandom_range(0, 1) == 1), ($urandom_range(0, 7) != 0), pcs[kt], tv,
           "R4");
    end
    step(1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 0, 0, "");
    @(negedge clk);
    check_pending();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule